// File: doc/BRIEF.md
# Limit-Match System Counter Timer

This block is a memory-mapped counter with a limit compare and a 32-bit word register port. An external strobe `tick` marks each 500 ns period. On every strobe the count goes up by one unit, and that unit sits at bit 9 of the 32-bit readback word. When a nonzero limit is programmed and the next step would bring the count up to that limit, the count goes back to zero on that same strobe. At the same time a sticky match flag is set and a level interrupt is raised.

Software sets up the block with two kinds of limit write. One restarts the count and the other leaves it alone. It services the interrupt by reading the limit register, and that read clears both the interrupt and the match flag. A limit of zero makes the block a free-running timebase that never flags and never interrupts. Read data is registered: it appears on `rdata` in the cycle after the one in which `rd_en` is sampled. The asynchronous active-low reset is released synchronously inside the block, through two stages.

Top module: `lmt_timer`

## Requirements
- R1: After reset, `irq` is low and every register reads as zero. This covers the limit register (word offset 0) and the count register (word offset 1).
- R2: A read of offset 1 returns the count unit in bits 30..9 and zero in bits 8..0. Each cycle with `tick` high adds 0x200 to the readback, and cycles without `tick` leave it unchanged.
- R3: With a nonzero limit L, the tick that would bring the count to L instead loads zero. On that same tick it sets the match flag (bit 31 of the offset 1 readback) and drives `irq` high. `irq` is a level and stays high while further ticks arrive.
- R4: A read of offset 0 returns the stored limit, masked to 31 bits. The same read clears both `irq` and the match flag. Read data appears on `rdata` one cycle after `rd_en`.
- R5: A write to offset 0 stores `wdata & 0x7FFFFE00` as the limit, restarts the count at zero and drops `irq`. It leaves the match flag unchanged.
- R6: A write to offset 2 stores `wdata & 0x7FFFFE00` as the limit and leaves the current count and flags untouched.
- R7: While the limit is zero, the count runs freely and never sets the match flag or `irq`. After the count reaches 0x7FFFFC00, the next tick returns it to zero.
- R8: Writes to offset 1 and to offsets 3 to 7 change no state. Reads of offsets 2 to 7 return zero.
- R9: If a limit match and a limit read fall in the same cycle, the match wins. The read returns the limit, and `irq` and the match flag are high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per 500 ns count period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt on limit match |

## Verification
The bench goes after the edge of the compare. A design that compares against the wrong value would flag one tick early or late, or would show the limit value itself in the count. A design that forgets the reload would keep counting past the limit. The bench also checks that the acknowledge really lives in the limit read: a design that clears on a count read, or never clears, leaves `irq` in the wrong state. It separates the two limit writes by the count they leave behind, and confirms that a restarting write keeps the match flag while it drops `irq`. It drives a match and an acknowledge in one cycle, where a design that lets the clear win would lose an interrupt. A zero limit must give no interrupt at all, and writes to the count and the unused offsets must leave no trace.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  // Word offsets whose decode the register port depends on
  localparam int unsigned OFF_LIMIT      = 0;
  localparam int unsigned OFF_COUNT      = 1;
  localparam int unsigned OFF_LIMIT_KEEP = 2;

  // Control strobes from the register port to the datapath
  typedef struct packed {
    logic load_rst;   // limit write that restarts the count
    logic load_keep;  // limit write that keeps the count
    logic ack;        // limit read: interrupt acknowledge
  } lmt_ctl_t;
endpackage

// File: rtl/lmt_rst_sync.sv
module lmt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/lmt_regif.sv
module lmt_regif
  import lmt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned UNIT_LSB = 9,
  parameter int unsigned ADDR_W   = 3,
  localparam int unsigned CNT_W   = DATA_W - 1 - UNIT_LSB
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  lim,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              reached,
  output lmt_ctl_t          ctl,
  output logic [CNT_W-1:0]  lim_in,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFF_LIMIT);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_KEEP  = ADDR_W'(OFF_LIMIT_KEEP);

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  // Write and read decode
  always_comb begin
    ctl.load_rst  = wr_en && (addr == A_LIMIT);
    ctl.load_keep = wr_en && (addr == A_KEEP);
    ctl.ack       = rd_en && (addr == A_LIMIT);
    lim_in        = wdata[DATA_W-2:UNIT_LSB];
  end

  // Read mux: unit field placed at UNIT_LSB, low bits zero
  always_comb begin
    case (addr)
      A_LIMIT: rd_mux = {1'b0, lim, {UNIT_LSB{1'b0}}};
      A_COUNT: rd_mux = {reached, cnt, {UNIT_LSB{1'b0}}};
      default: rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R8: offsets with no readable register return zero
  p_undef_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && addr != A_LIMIT && addr != A_COUNT) |=> (rdata == '0));

  // R4: limit readback never carries bit 31
  p_limit_read_masked_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && addr == A_LIMIT) |=> (rdata[DATA_W-1] == 1'b0 && rdata[UNIT_LSB-1:0] == '0));
endmodule

// File: rtl/lmt_count.sv
module lmt_count
  import lmt_pkg::*;
#(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             tick,
  input  lmt_ctl_t         ctl,
  input  logic [CNT_W-1:0] lim_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim,
  output logic             match
);
  localparam logic [CNT_W-1:0] CNT_ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] lim_eff;
  logic             lim_zero;
  logic             wrap;

  // Next-state logic
  always_comb begin
    lim_zero = (lim_q == '0);
    lim_eff  = lim_zero ? CNT_ONES : lim_q;
    cnt_inc  = cnt_q + CNT_W'(1);
    wrap     = (cnt_inc == lim_eff);
    match    = tick && !ctl.load_rst && wrap && !lim_zero;

    lim_d = lim_q;
    if (ctl.load_rst || ctl.load_keep) lim_d = lim_in;

    cnt_d = cnt_q;
    if (ctl.load_rst)  cnt_d = '0;
    else if (tick)     cnt_d = wrap ? '0 : cnt_inc;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign cnt = cnt_q;
  assign lim = lim_q;

  // R5: restarting limit write zeroes the count
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    ctl.load_rst |=> (cnt == '0));

  // R6: keeping limit write leaves the count alone
  p_keep_count_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctl.load_keep && !ctl.load_rst && !tick) |=> (cnt == $past(cnt) && lim == $past(lim_in)));

  // R2: no tick, no restart, no change
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!tick && !ctl.load_rst) |=> $stable(cnt));

  // R2: a tick below the limit adds one unit
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick && !ctl.load_rst && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R3: a match reloads zero on the same tick
  p_match_reload_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    match |=> (cnt == '0));

  // R7: zero limit never matches, and wraps below all ones
  p_freerun_nomatch_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (lim == '0) |-> !match);
  p_freerun_wrap_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick && !ctl.load_rst && lim == '0 && cnt == CNT_ONES - CNT_W'(1)) |=> (cnt == '0));
endmodule

// File: rtl/lmt_flags.sv
module lmt_flags
  import lmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ns,
  input  logic     match,
  input  lmt_ctl_t ctl,
  output logic     reached,
  output logic     irq
);
  logic reached_q, reached_d;
  logic irq_q, irq_d;

  // Set wins over acknowledge so a match is never lost
  always_comb begin
    reached_d = reached_q;
    irq_d     = irq_q;
    if (match) begin
      reached_d = 1'b1;
      irq_d     = 1'b1;
    end else begin
      if (ctl.ack)                irq_d     = 1'b0;
      if (ctl.ack)                reached_d = 1'b0;
      if (ctl.load_rst)           irq_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      reached_q <= reached_d;
      irq_q     <= irq_d;
    end
  end

  assign reached = reached_q;
  assign irq     = irq_q;

  // R3: interrupt only stands with the flag set
  p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    irq |-> reached);

  // R3 / R9: a match raises both outputs
  p_match_sets_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    match |=> (irq && reached));

  // R4: acknowledge clears both when no match competes
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctl.ack && !match) |=> (!irq && !reached));

  // R5: restarting limit write drops the interrupt, keeps the flag
  p_load_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctl.load_rst && !ctl.ack && !match) |=> (!irq && reached == $past(reached)));
endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
  import lmt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned UNIT_LSB = 9,
  parameter int unsigned ADDR_W   = 3,
  localparam int unsigned CNT_W   = DATA_W - 1 - UNIT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             rst_ns;
  lmt_ctl_t         ctl;
  logic [CNT_W-1:0] lim_in;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             match;
  logic             reached;

  lmt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  lmt_regif #(.DATA_W(DATA_W), .UNIT_LSB(UNIT_LSB), .ADDR_W(ADDR_W)) u_regif (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .lim     (lim),
    .cnt     (cnt),
    .reached (reached),
    .ctl     (ctl),
    .lim_in  (lim_in),
    .rdata   (rdata)
  );

  lmt_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_ns (rst_ns),
    .tick   (tick),
    .ctl    (ctl),
    .lim_in (lim_in),
    .cnt    (cnt),
    .lim    (lim),
    .match  (match)
  );

  lmt_flags u_flags (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .match   (match),
    .ctl     (ctl),
    .reached (reached),
    .irq     (irq)
  );

  // R1: reset leaves no interrupt pending
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ns |-> (!irq && rdata == '0));
endmodule

// File: tb/sim_lmt_timer.sv
module sim_lmt_timer;
  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_TK  = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int N = 53;
  localparam vec_t TBL [N] = '{
    '{OP_RD,  3'd1, 32'h0,        32'h0,        4'd1},  // R1 count zero
    '{OP_RD,  3'd0, 32'h0,        32'h0,        4'd1},  // R1 limit zero
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd1},  // R1 irq low
    '{OP_TK,  3'd0, 32'd3,        32'h0,        4'd2},
    '{OP_RD,  3'd1, 32'h0,        32'h600,      4'd2},  // R2 three units
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd7},  // R7 free run quiet
    '{OP_WR,  3'd0, 32'hFFFFFFFF, 32'h0,        4'd5},
    '{OP_RD,  3'd1, 32'h0,        32'h0,        4'd5},  // R5 restart
    '{OP_RD,  3'd0, 32'h0,        32'h7FFFFE00, 4'd4},  // R4 masked limit
    '{OP_WR,  3'd0, 32'h00000A55, 32'h0,        4'd5},
    '{OP_TK,  3'd0, 32'd4,        32'h0,        4'd2},
    '{OP_RD,  3'd1, 32'h0,        32'h800,      4'd2},
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd3},  // R3 not yet
    '{OP_TK,  3'd0, 32'd1,        32'h0,        4'd3},
    '{OP_RD,  3'd1, 32'h0,        32'h80000000, 4'd3},  // R3 reload + flag
    '{OP_IRQ, 3'd0, 32'h0,        32'h1,        4'd3},
    '{OP_TK,  3'd0, 32'd2,        32'h0,        4'd3},
    '{OP_RD,  3'd1, 32'h0,        32'h80000400, 4'd3},
    '{OP_IRQ, 3'd0, 32'h0,        32'h1,        4'd3},  // R3 level held
    '{OP_RD,  3'd0, 32'h0,        32'h00000A00, 4'd4},  // R4 ack
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd4},
    '{OP_RD,  3'd1, 32'h0,        32'h400,      4'd4},  // R4 flag cleared
    '{OP_WR,  3'd2, 32'h00001000, 32'h0,        4'd6},
    '{OP_RD,  3'd1, 32'h0,        32'h400,      4'd6},  // R6 count kept
    '{OP_TK,  3'd0, 32'd5,        32'h0,        4'd6},
    '{OP_RD,  3'd1, 32'h0,        32'hE00,      4'd6},
    '{OP_TK,  3'd0, 32'd1,        32'h0,        4'd6},
    '{OP_RD,  3'd1, 32'h0,        32'h80000000, 4'd6},  // R6 new limit used
    '{OP_IRQ, 3'd0, 32'h0,        32'h1,        4'd6},
    '{OP_RD,  3'd0, 32'h0,        32'h00001000, 4'd4},
    '{OP_TK,  3'd0, 32'd3,        32'h0,        4'd8},
    '{OP_WR,  3'd1, 32'h12345600, 32'h0,        4'd8},
    '{OP_RD,  3'd1, 32'h0,        32'h600,      4'd8},  // R8 count write ignored
    '{OP_WR,  3'd3, 32'hFFFFFFFF, 32'h0,        4'd8},
    '{OP_WR,  3'd4, 32'hFFFFFFFF, 32'h0,        4'd8},
    '{OP_WR,  3'd7, 32'hFFFFFFFF, 32'h0,        4'd8},
    '{OP_RD,  3'd0, 32'h0,        32'h00001000, 4'd8},  // R8 limit untouched
    '{OP_RD,  3'd2, 32'h0,        32'h0,        4'd8},
    '{OP_RD,  3'd3, 32'h0,        32'h0,        4'd8},
    '{OP_RD,  3'd4, 32'h0,        32'h0,        4'd8},
    '{OP_RD,  3'd7, 32'h0,        32'h0,        4'd8},
    '{OP_WR,  3'd0, 32'h0,        32'h0,        4'd7},
    '{OP_TK,  3'd0, 32'd10,       32'h0,        4'd7},
    '{OP_RD,  3'd1, 32'h0,        32'h1400,     4'd7},  // R7 free count
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd7},
    '{OP_WR,  3'd0, 32'h00000400, 32'h0,        4'd5},
    '{OP_TK,  3'd0, 32'd2,        32'h0,        4'd3},
    '{OP_IRQ, 3'd0, 32'h0,        32'h1,        4'd3},
    '{OP_WR,  3'd0, 32'h00000400, 32'h0,        4'd5},
    '{OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd5},  // R5 irq dropped
    '{OP_RD,  3'd1, 32'h0,        32'h80000000, 4'd5},  // R5 flag kept
    '{OP_RD,  3'd0, 32'h0,        32'h00000400, 4'd4},
    '{OP_RD,  3'd1, 32'h0,        32'h0,        4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lmt_timer u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_tk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    check("R1 rdata in reset", rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < N; i++) begin
      case (TBL[i].op)
        OP_WR: do_wr(TBL[i].adr, TBL[i].dat);
        OP_TK: do_tk(int'(TBL[i].dat));
        OP_RD: begin
          do_rd(TBL[i].adr, d);
          check($sformatf("R%0d vec %0d read", TBL[i].req, i), d, TBL[i].exp);
        end
        default: begin
          @(negedge clk);
          check($sformatf("R%0d vec %0d irq", TBL[i].req, i), {31'b0, irq}, TBL[i].exp);
        end
      endcase
    end

    // R9: match and acknowledge in the same cycle
    do_wr(3'd0, 32'h00000400);
    do_tk(1);
    @(negedge clk);
    tick = 1'b1; rd_en = 1'b1; addr = 3'd0;
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
    check("R9 read returns limit", rdata, 32'h00000400);
    check("R9 irq survives ack", {31'b0, irq}, 32'h1);
    do_rd(3'd1, d);
    check("R9 flag survives ack", d, 32'h80000000);

    // R1: reset in the middle of a run
    do_tk(1);
    do_reset();
    do_rd(3'd0, d);
    check("R1 limit after reset", d, 32'h0);
    do_rd(3'd1, d);
    check("R1 count after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule